// File: doc/BRIEF.md
# Mode-Controlled Up/Down Counter

This block is a small synchronous counter whose behaviour on every rising clock edge is chosen by a two-bit mode code. The four codes select one of four actions. The counter can be cleared to zero, stepped up by one, stepped down by one, or frozen at its present value. The count is `CNT_W` bits wide and defaults to 3 bits. Stepping past either end of the range wraps around to the other end.

Two combinational flags warn that the next edge will wrap. One flag covers counting up and the other covers counting down. A neighbouring block can use them to extend the range or to start a follow-on event. An active-high reset, sampled on the clock edge, returns the count to zero and takes priority over the mode code.

Top module: `updn_mode_counter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `count` is 0 after that edge.
- R2: Mode code 2'b00 makes `count` 0 after the next rising edge, whatever its previous value.
- R3: Mode code 2'b01 makes `count` one greater after the next rising edge, when the previous value is below the maximum.
- R4: Mode code 2'b10 makes `count` one smaller after the next rising edge, when the previous value is above 0.
- R5: Mode code 2'b11 leaves `count` unchanged across the rising edge.
- R6: With mode 2'b01 and `count` at its maximum (2**CNT_W-1, which is 7 by default), `count` becomes 0 after the edge.
- R7: With mode 2'b10 and `count` at 0, `count` becomes the maximum (7 by default) after the edge.
- R8: `up_term` is 1 exactly when `count` is at its maximum and the mode is 2'b01. It is combinational and does not depend on `rst`.
- R9: `dn_term` is 1 exactly when `count` is 0 and the mode is 2'b10. It is combinational and does not depend on `rst`.
- R10: When `rst` is high, `count` is 0 after the edge, even when the mode code requests a step up, a step down or a hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero |
| mode | input | 2 | Action code: 00 clear, 01 up, 10 down, 11 hold |
| count | output | CNT_W | Present count value |
| up_term | output | 1 | Count at maximum while counting up |
| dn_term | output | 1 | Count at zero while counting down |

## Verification
The bench builds the counter with its default width of 3 bits. At that width there are only eight count values and four mode codes, so every combination of value and mode is driven from a known starting point. This includes both wrap points and the two flag conditions. A long pseudo-random sequence of mode codes, with occasional resets, then runs against an arithmetic model of the counter. This reaches back-to-back direction changes and resets that arrive while the counter is in any mode.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'b00,
        MODE_UP    = 2'b01,
        MODE_DOWN  = 2'b10,
        MODE_HOLD  = 2'b11
    } mode_e;

    typedef struct packed {
        logic clr;
        logic inc;
        logic dec;
        logic keep;
    } action_t;

    function automatic action_t decode_mode(input mode_e m);
        action_t a;
        a = '0;
        unique case (m)
            MODE_CLEAR: a.clr  = 1'b1;
            MODE_UP:    a.inc  = 1'b1;
            MODE_DOWN:  a.dec  = 1'b1;
            default:    a.keep = 1'b1;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/updn_decode.sv
module updn_decode
    import updn_pkg::*;
(
    input  logic [1:0] mode_raw,
    output action_t    act
);
    always_comb begin
        act = decode_mode(mode_e'(mode_raw));
    end
endmodule

// File: rtl/updn_step.sv
module updn_step
    import updn_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] cur,
    input  action_t          act,
    output logic [CNT_W-1:0] nxt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        if (act.clr)
            nxt = '0;
        else if (act.inc)
            nxt = cur + ONE;
        else if (act.dec)
            nxt = cur - ONE;
        else
            nxt = cur;
    end
endmodule

// File: rtl/updn_term.sv
module updn_term
    import updn_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] cur,
    input  action_t          act,
    output logic             at_top_up,
    output logic             at_bottom_dn
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_comb begin
        at_top_up    = act.inc && (cur == TOP);
        at_bottom_dn = act.dec && (cur == '0);
    end

    always_comb begin
        assert_flags_exclusive_R8: assert (!(at_top_up && at_bottom_dn))
            else $error("both terminal flags high");
    end
endmodule

// File: rtl/updn_mode_counter.sv
module updn_mode_counter
    import updn_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    output logic [CNT_W-1:0] count,
    output logic             up_term,
    output logic             dn_term
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    action_t          act;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    updn_decode u_decode (
        .mode_raw (mode),
        .act      (act)
    );

    updn_step #(.CNT_W(CNT_W)) u_step (
        .cur (cnt_q),
        .act (act),
        .nxt (cnt_d)
    );

    updn_term #(.CNT_W(CNT_W)) u_term (
        .cur          (cnt_q),
        .act          (act),
        .at_top_up    (up_term),
        .at_bottom_dn (dn_term)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (count == '0));

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> (count == '0));

    assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && count != TOP) |=> (count == $past(count) + ONE));

    assert_down_step_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && count != '0) |=> (count == $past(count) - ONE));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> $stable(count));

    assert_up_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        up_term |=> (count == '0));

    assert_down_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        dn_term |=> (count == TOP));

    assert_upterm_mode_R8: assert property (@(posedge clk)
        up_term |-> (mode == 2'b01));

    assert_dnterm_mode_R9: assert property (@(posedge clk)
        dn_term |-> (mode == 2'b10));
endmodule

// File: tb/updn_mode_counter_bench.sv
module updn_mode_counter_bench;
    localparam int W    = 3;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'b11;
    logic [W-1:0] count;
    logic         up_term;
    logic         dn_term;

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    updn_mode_counter #(.CNT_W(W)) u_updn_mode_counter (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .count   (count),
        .up_term (up_term),
        .dn_term (dn_term)
    );

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Called just after a falling edge: drives inputs, checks flags, then
    // checks the registered count at the following falling edge.
    task automatic step(input logic r, input logic [1:0] m);
        int nxt;
        string tag;
        rst  = r;
        mode = m;
        #1;
        chk("R8 up_term", int'(up_term), int'(exp_cnt == MAXV && m == 2'b01));
        chk("R9 dn_term", int'(dn_term), int'(exp_cnt == 0 && m == 2'b10));
        case (m)
            2'b00: begin nxt = 0;                       tag = "R2 clear"; end
            2'b01: begin nxt = (exp_cnt + 1) % (MAXV + 1);
                         tag = (exp_cnt == MAXV) ? "R6 up wrap" : "R3 up"; end
            2'b10: begin nxt = (exp_cnt + MAXV) % (MAXV + 1);
                         tag = (exp_cnt == 0) ? "R7 down wrap" : "R4 down"; end
            default: begin nxt = exp_cnt;               tag = "R5 hold"; end
        endcase
        if (r) begin
            nxt = 0;
            tag = (m == 2'b00) ? "R1 reset" : "R10 reset priority";
        end
        @(posedge clk);
        @(negedge clk);
        exp_cnt = nxt;
        chk(tag, int'(count), exp_cnt);
    endtask

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        step(1'b1, 2'b00);
        chk("R1 reset state", int'(count), 0);
        step(1'b1, 2'b01);
        step(1'b1, 2'b10);
        step(1'b1, 2'b11);

        // Exhaustive: every start value with every mode code
        for (int s = 0; s <= MAXV; s++) begin
            for (int m = 0; m < 4; m++) begin
                step(1'b0, 2'b00);
                for (int k = 0; k < s; k++) step(1'b0, 2'b01);
                step(1'b0, 2'(m));
                step(1'b0, 2'b11);
            end
        end

        // Full down sweep through the lower wrap point twice
        for (int k = 0; k < 2 * (MAXV + 1); k++) step(1'b0, 2'b10);

        // Pseudo-random mode sequence with occasional resets
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:2] == 6'd0, lfsr[1:0]);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule